// File: doc/BRIEF.md
# Successive-Approximation Converter Handshake Controller

This block is the host-side sequencer for an external 8-bit successive-approximation converter. The converter has four active-low control lines: chip select, write, read and conversion-done. On a start request the controller drives write low with chip select held low, which holds the converter in reset. It then releases write while chip select is still low, and that rising edge starts a conversion. The controller waits for the done line, seen through a synchronizer, to fall. It then runs a read cycle, samples the data bus and hands the byte to the system with a one-cycle valid strobe.

A single request gives one result. With the continuous input high, the controller starts the next conversion by itself after each read. It stops after the current result once that input drops. A new request while the write pulse or the conversion wait is in progress abandons that conversion and issues a fresh write pulse. If the done line never falls, a timeout counted in system clocks raises an error flag and the controller returns to idle. Every pulse width and the timeout are parameters in system clocks.

Top module: `adc_handshake_ctrl`

## Requirements
- R1: After reset, chip select, write and read are high (inactive), and busy, resultValid and timeoutErr are low.
- R2: An accepted start drives write low with chip select low for exactly WR_LOW_CYC clocks. Write then rises while chip select stays low for one more clock, and only after that is chip select released.
- R3: Read is never driven low for a conversion until the done line has been seen low after the write pulse that started it.
- R4: The read cycle asserts chip select for one clock alone, then holds read low for RD_SAMPLE_CYC clocks and samples the data bus at the end of that window. Read rises while chip select is still low. Write and read are never low together.
- R5: The sampled byte appears on resultData together with a resultValid pulse that lasts exactly one clock.
- R6: busy is high from the clock after a start is accepted up to and including the resultValid clock. In single-shot mode it is low on the clock after that.
- R7: A start request during the write pulse or the conversion wait restarts the write pulse. The abandoned conversion produces no result; only the restarted one does.
- R8: With contMode high, a new write pulse follows each result without any start request. Dropping contMode before the end of a read cycle makes that result the last one.
- R9: If the done line is not seen low within TIMEOUT_CYC clocks of entering the wait, timeoutErr is set, busy drops and no result is produced. timeoutErr stays set until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-clock request to begin (or restart) a conversion |
| contMode | input | 1 | High selects continuous conversions |
| adcIntrN | input | 1 | Converter done line, active low, asynchronous |
| adcData | input | DATA_W | Converter data bus |
| adcCsN | output | 1 | Converter chip select, active low |
| adcWrN | output | 1 | Converter write/start strobe, active low |
| adcRdN | output | 1 | Converter read strobe, active low |
| resultData | output | DATA_W | Last captured conversion result |
| resultValid | output | 1 | One-clock strobe marking a new result |
| busy | output | 1 | Conversion sequence in progress |
| timeoutErr | output | 1 | Done line failed to fall in time |

## Verification
The bench targets the restart case. A second start lands in the middle of a conversion, and the converter model latches a different value for each write edge. A controller that ignores the restart delivers the stale first value, or delivers two results. A run with a converter that never finishes checks that the error flag rises, that busy falls and that no stray valid appears, and that the next start clears the flag. Continuous mode is checked by counting exactly three results after contMode is dropped on the third. A late-stopping controller would produce a fourth. Monitors measure the write and read pulse widths, and they flag any read that begins before the done line fell, as a design that skipped the synchronizer or the wait would do.

// File: rtl/adc_hs_pkg.sv
package adc_hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LOW,
    ST_WR_REL,
    ST_WAIT,
    ST_RD_SETUP,
    ST_RD_LOW,
    ST_RD_REL
  } hsState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic phaseClr;
    logic waitRun;
    logic capture;
    logic errSet;
    logic errClr;
  } hsCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic wrDone;
    logic rdDone;
    logic intrLow;
    logic timeoutHit;
  } hsStat_t;

endpackage

// File: rtl/adc_hs_dpath.sv
module adc_hs_dpath
  import adc_hs_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int WR_LOW_CYC    = 4,
  parameter int RD_SAMPLE_CYC = 3,
  parameter int TIMEOUT_CYC   = 200,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  hsCmd_t            cmd,
  input  logic              adcIntrN,
  input  logic [DATA_W-1:0] adcData,
  output hsStat_t           stat,
  output logic [DATA_W-1:0] resultData,
  output logic              resultValid,
  output logic              timeoutErr
);

  localparam int PHASE_MAX = (WR_LOW_CYC > RD_SAMPLE_CYC) ? WR_LOW_CYC : RD_SAMPLE_CYC;
  localparam int PHASE_W   = $clog2(PHASE_MAX + 1);
  localparam int TO_W      = $clog2(TIMEOUT_CYC + 1);

  logic [PHASE_W-1:0]     phaseCnt;
  logic [TO_W-1:0]        waitCnt;
  logic [SYNC_STAGES-1:0] intrSync;

  // shared phase counter for the write-low and read-low windows
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 phaseCnt <= '0;
    else if (cmd.phaseClr)                     phaseCnt <= '0;
    else if (phaseCnt != PHASE_W'(PHASE_MAX))  phaseCnt <= phaseCnt + 1'b1;
  end

  // timeout counter, live only while waiting for the done line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    waitCnt <= '0;
    else if (!cmd.waitRun)                        waitCnt <= '0;
    else if (waitCnt != TO_W'(TIMEOUT_CYC))       waitCnt <= waitCnt + 1'b1;
  end

  // done-line synchronizer, idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intrSync <= '1;
    else       intrSync <= {intrSync[SYNC_STAGES-2:0], adcIntrN};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultData  <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= cmd.capture;
      if (cmd.capture) resultData <= adcData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             timeoutErr <= 1'b0;
    else if (cmd.errClr)   timeoutErr <= 1'b0;
    else if (cmd.errSet)   timeoutErr <= 1'b1;
  end

  always_comb begin
    stat.wrDone     = (phaseCnt == PHASE_W'(WR_LOW_CYC - 1));
    stat.rdDone     = (phaseCnt == PHASE_W'(RD_SAMPLE_CYC - 1));
    stat.intrLow    = ~intrSync[SYNC_STAGES-1];
    stat.timeoutHit = cmd.waitRun && (waitCnt == TO_W'(TIMEOUT_CYC - 1));
  end

endmodule

// File: rtl/adc_hs_ctrl.sv
module adc_hs_ctrl
  import adc_hs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    contMode,
  input  hsStat_t stat,
  output hsCmd_t  cmd,
  output logic    adcCsN,
  output logic    adcWrN,
  output logic    adcRdN,
  output logic    busy
);

  hsState_t state, stateNext;
  logic     restart;
  logic     accept;

  // a start during write or wait abandons the running conversion
  assign restart = startReq && (state == ST_WR_LOW || state == ST_WAIT);
  assign accept  = (startReq && state == ST_IDLE) || restart;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     if (startReq) stateNext = ST_WR_LOW;
      ST_WR_LOW:   if (!restart && stat.wrDone) stateNext = ST_WR_REL;
      ST_WR_REL:   stateNext = ST_WAIT;
      ST_WAIT: begin
        if (startReq)             stateNext = ST_WR_LOW;
        else if (stat.intrLow)    stateNext = ST_RD_SETUP;
        else if (stat.timeoutHit) stateNext = ST_IDLE;
      end
      ST_RD_SETUP: stateNext = ST_RD_LOW;
      ST_RD_LOW:   if (stat.rdDone) stateNext = ST_RD_REL;
      ST_RD_REL:   stateNext = contMode ? ST_WR_LOW : ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // pins registered from the next state: no decode glitches at the pads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adcCsN <= 1'b1;
      adcWrN <= 1'b1;
      adcRdN <= 1'b1;
    end else begin
      adcCsN <= !(stateNext inside {ST_WR_LOW, ST_WR_REL, ST_RD_SETUP, ST_RD_LOW, ST_RD_REL});
      adcWrN <= (stateNext != ST_WR_LOW);
      adcRdN <= (stateNext != ST_RD_LOW);
    end
  end

  always_comb begin
    cmd.phaseClr = (stateNext != state) || restart;
    cmd.waitRun  = (state == ST_WAIT);
    cmd.capture  = (state == ST_RD_LOW) && stat.rdDone;
    cmd.errSet   = (state == ST_WAIT) && !startReq && !stat.intrLow && stat.timeoutHit;
    cmd.errClr   = accept;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/adc_handshake_ctrl.sv
module adc_handshake_ctrl
  import adc_hs_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int WR_LOW_CYC    = 4,
  parameter int RD_SAMPLE_CYC = 3,
  parameter int TIMEOUT_CYC   = 200,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              contMode,
  input  logic              adcIntrN,
  input  logic [DATA_W-1:0] adcData,
  output logic              adcCsN,
  output logic              adcWrN,
  output logic              adcRdN,
  output logic [DATA_W-1:0] resultData,
  output logic              resultValid,
  output logic              busy,
  output logic              timeoutErr
);

  hsCmd_t  cmd;
  hsStat_t stat;

  adc_hs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .contMode (contMode),
    .stat     (stat),
    .cmd      (cmd),
    .adcCsN   (adcCsN),
    .adcWrN   (adcWrN),
    .adcRdN   (adcRdN),
    .busy     (busy)
  );

  adc_hs_dpath #(
    .DATA_W        (DATA_W),
    .WR_LOW_CYC    (WR_LOW_CYC),
    .RD_SAMPLE_CYC (RD_SAMPLE_CYC),
    .TIMEOUT_CYC   (TIMEOUT_CYC),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .adcIntrN    (adcIntrN),
    .adcData     (adcData),
    .stat        (stat),
    .resultData  (resultData),
    .resultValid (resultValid),
    .timeoutErr  (timeoutErr)
  );

endmodule

// File: rtl/adc_hs_checker.sv
module adc_hs_checker #(
  parameter int DATA_W     = 8,
  parameter int WR_LOW_CYC = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              adcIntrN,
  input logic              adcCsN,
  input logic              adcWrN,
  input logic              adcRdN,
  input logic [DATA_W-1:0] resultData,
  input logic              resultValid,
  input logic              busy,
  input logic              timeoutErr
);

  int   wrLowLen;
  logic doneSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        wrLowLen <= 0;
    else if (!adcWrN) wrLowLen <= wrLowLen + 1;
    else              wrLowLen <= 0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          doneSeen <= 1'b0;
    else if (!adcWrN)   doneSeen <= 1'b0;
    else if (!adcIntrN) doneSeen <= 1'b1;
  end

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (adcCsN && adcWrN && adcRdN)); // R1
  AST_WR_UNDER_CS: assert property (@(posedge clk) disable iff (!rstN)
    !adcWrN |-> !adcCsN); // R2
  AST_WR_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcWrN) |-> (wrLowLen >= WR_LOW_CYC && !adcCsN)); // R2
  AST_RD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcRdN) |-> doneSeen); // R3
  AST_NO_WR_RD_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(!adcWrN && !adcRdN)); // R4
  AST_RD_UNDER_CS: assert property (@(posedge clk) disable iff (!rstN)
    !adcRdN |-> !adcCsN); // R4
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid); // R5
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(resultData)); // R5
  AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> busy); // R6
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> (!busy && !resultValid)); // R9

endmodule

bind adc_handshake_ctrl adc_hs_checker #(
  .DATA_W     (DATA_W),
  .WR_LOW_CYC (WR_LOW_CYC)
) u_hsChecker (
  .clk         (clk),
  .rstN        (rstN),
  .adcIntrN    (adcIntrN),
  .adcCsN      (adcCsN),
  .adcWrN      (adcWrN),
  .adcRdN      (adcRdN),
  .resultData  (resultData),
  .resultValid (resultValid),
  .busy        (busy),
  .timeoutErr  (timeoutErr)
);

// File: tb/test_adc_handshake_ctrl.sv
module test_adc_handshake_ctrl;

  localparam int WR_LOW_CYC    = 4;
  localparam int RD_SAMPLE_CYC = 3;
  localparam int TIMEOUT_CYC   = 200;

  // {base value, converter delay in clocks; 0 = never finishes}
  localparam logic [15:0] VEC [6] = '{
    {8'h00, 8'd66}, {8'hFF, 8'd72}, {8'h5A, 8'd65},
    {8'hA5, 8'd70}, {8'h3C, 8'd0},  {8'h81, 8'd68}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       contMode = 1'b0;
  logic       adcIntrN = 1'b1;
  logic [7:0] adcData;
  logic       adcCsN, adcWrN, adcRdN;
  logic [7:0] resultData;
  logic       resultValid, busy, timeoutErr;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  adc_handshake_ctrl #(
    .DATA_W(8), .WR_LOW_CYC(WR_LOW_CYC), .RD_SAMPLE_CYC(RD_SAMPLE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC), .SYNC_STAGES(2)
  ) i_adc_handshake_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .contMode(contMode),
    .adcIntrN(adcIntrN), .adcData(adcData), .adcCsN(adcCsN), .adcWrN(adcWrN),
    .adcRdN(adcRdN), .resultData(resultData), .resultValid(resultValid),
    .busy(busy), .timeoutErr(timeoutErr)
  );

  // ---------------- converter model ----------------
  int         convDelay = 66;
  logic [7:0] convBase = 8'h00;
  int         startCnt = 0;
  int         cnt = 0;
  logic       wrPrev = 1'b1;
  logic [7:0] held = 8'h00;
  logic       convDone = 1'b0;

  assign adcData = (!adcCsN && !adcRdN) ? held : 8'hE7;

  always @(posedge clk) begin
    wrPrev <= adcWrN;
    if (!adcCsN && !adcWrN) begin
      cnt <= 0; adcIntrN <= 1'b1; convDone <= 1'b0;
    end else if (!wrPrev && adcWrN && !adcCsN) begin
      startCnt <= startCnt + 1;
      held     <= convBase + 8'(startCnt);
      cnt      <= convDelay;
    end else if (cnt > 1) begin
      cnt <= cnt - 1;
    end else if (cnt == 1) begin
      cnt <= 0; adcIntrN <= 1'b0; convDone <= 1'b1;
    end
    if (!adcCsN && !adcRdN) adcIntrN <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- pin monitors ----------------
  int   wrLowCnt = 0;
  int   rdLowCnt = 0;
  logic wrSeen = 1'b1;
  logic rdSeen = 1'b1;
  int   validCnt = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!wrSeen && adcWrN) begin
        chk(wrLowCnt == WR_LOW_CYC, "R2 write width", wrLowCnt, WR_LOW_CYC);
        chk(!adcCsN, "R2 cs held at write rise", int'(adcCsN), 0);
      end
      if (rdSeen && !adcRdN)
        chk(convDone, "R3 read before done", int'(convDone), 1);
      if (!rdSeen && adcRdN) begin
        chk(rdLowCnt == RD_SAMPLE_CYC, "R4 read width", rdLowCnt, RD_SAMPLE_CYC);
        chk(!adcCsN, "R4 cs held at read rise", int'(adcCsN), 0);
      end
      if (!adcWrN && !adcRdN) chk(1'b0, "R4 write/read overlap", 1, 0);
      if (resultValid) validCnt++;
    end
    wrLowCnt = adcWrN ? 0 : wrLowCnt + 1;
    rdLowCnt = adcRdN ? 0 : rdLowCnt + 1;
    wrSeen = adcWrN;
    rdSeen = adcRdN;
  end

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  task automatic waitEnd(output bit gotValid);
    gotValid = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      if (resultValid) begin gotValid = 1'b1; break; end
      if (timeoutErr) break;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    bit         got;
    int         snap;
    int         vBefore;
    logic [7:0] expv;

    repeat (4) @(negedge clk);
    // R1 reset state
    chk(adcCsN && adcWrN && adcRdN, "R1 pins idle", {adcCsN, adcWrN, adcRdN}, 7);
    chk(!busy && !resultValid && !timeoutErr, "R1 flags low",
        {busy, resultValid, timeoutErr}, 0);
    @(negedge clk) rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(adcCsN && adcWrN && adcRdN && !busy, "R1 idle after release",
        {adcCsN, adcWrN, adcRdN, busy}, 14);

    // table walk: single shots and one timeout
    for (int v = 0; v < 6; v++) begin
      convBase  = VEC[v][15:8];
      convDelay = int'(VEC[v][7:0]);
      snap      = startCnt;
      vBefore   = validCnt;
      pulseStart();
      chk(busy, "R6 busy after start", int'(busy), 1);
      chk(!timeoutErr, "R9 error cleared by start", int'(timeoutErr), 0);
      waitEnd(got);
      if (convDelay != 0) begin
        expv = convBase + 8'(snap);
        chk(got, "R5 result delivered", int'(got), 1);
        chk(resultData == expv, "R5 result data", int'(resultData), int'(expv));
        chk(busy, "R6 busy during valid", int'(busy), 1);
        @(negedge clk);
        chk(!resultValid, "R5 valid one clock", int'(resultValid), 0);
        chk(!busy, "R6 busy drops after result", int'(busy), 0);
      end else begin
        chk(timeoutErr, "R9 timeout flagged", int'(timeoutErr), 1);
        chk(!busy, "R9 idle after timeout", int'(busy), 0);
        chk(validCnt == vBefore, "R9 no result on timeout", validCnt, vBefore);
        repeat (5) @(negedge clk);
        chk(timeoutErr, "R9 error holds", int'(timeoutErr), 1);
      end
      repeat (3) @(negedge clk);
    end

    // R7 abort by restart during the conversion wait
    convBase  = 8'h40;
    convDelay = 70;
    snap      = startCnt;
    vBefore   = validCnt;
    pulseStart();
    repeat (20) @(negedge clk);
    pulseStart();
    waitEnd(got);
    expv = convBase + 8'(snap + 1);
    chk(got, "R7 restarted conversion completes", int'(got), 1);
    chk(resultData == expv, "R7 result from restart", int'(resultData), int'(expv));
    repeat (150) @(negedge clk);
    chk(validCnt == vBefore + 1, "R7 single result", validCnt - vBefore, 1);

    // R8 continuous mode, stop after third result
    convBase  = 8'h10;
    convDelay = 65;
    snap      = startCnt;
    vBefore   = validCnt;
    contMode  = 1'b1;
    pulseStart();
    for (int k = 0; k < 3; k++) begin
      waitEnd(got);
      expv = convBase + 8'(snap + k);
      chk(got, "R8 continuous result", int'(got), 1);
      chk(resultData == expv, "R8 continuous data", int'(resultData), int'(expv));
      if (k == 2) contMode = 1'b0;
      @(negedge clk);
    end
    repeat (200) @(negedge clk);
    chk(validCnt == vBefore + 3, "R8 stops after last", validCnt - vBefore, 3);
    chk(!busy, "R8 idle after stop", int'(busy), 0);

    summary();
  end

endmodule